// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block sits on the path of every memory access that falls in the low legacy window of a PC address map, from 0xA0000 up to 0xFFFFF. For each request it reports on the same cycle where the access goes. The possible answers are local DRAM, the PCI bus, a blocked write, or "not claimed" when the address lies below the window.

Routing is controlled by two kinds of state. Seven 8-bit attribute registers hold a 2-bit read/write attribute for each shadowable segment, packed two segments to a register. One 8-bit control register gates the system-management RAM window at 0xA0000–0xBFFFF. That window can be forced open, or opened only while the system-management mode input is asserted.

Software-side plumbing reaches the registers through a small write port with a select and a combinational readback. The routing answer is derived from registered state only, so a register write or a mode change is seen by accesses from the next cycle on.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset every register reads zero, except the SMRAM control register, which reads 0x02. Every access in 0xA0000–0xFFFFF then routes to PCI.
- R2: `route_o` is 2'b00 (none) when `req_valid` is low, and also for any address below 0xA0000. The other encodings are 2'b01 DRAM, 2'b10 PCI and 2'b11 blocked.
- R3: Accesses in 0xF0000–0xFFFFF use bits 5:4 of attribute register 0 (`cfg_sel`=0). Bits 3:0 of that register affect no routing.
- R4: Segment k (0..11) covers 0xC0000+k*0x4000 for 16 KB. Its attribute is bits 1:0 of register k/2+1 when k is even, and bits 5:4 of that register when k is odd.
- R5: Attribute 2'b11 (bit 0 read-enable, bit 1 write-enable) sends both reads and writes to DRAM.
- R6: Attribute 2'b01 sends reads to DRAM and marks writes as blocked.
- R7: Attribute 2'b10 or 2'b00 sends both reads and writes to PCI.
- R8: Bits 3:2 of each nibble are ignored. For example, nibble 0xD routes exactly like 0x1.
- R9: Accesses in 0xA0000–0xBFFFF, reads and writes alike, go to DRAM when control bit 6 (open) is set, or when bit 3 (global enable) is set and the registered SMM level is high. Otherwise they go to PCI.
- R10: The `smm_active` level is captured into a register only when it differs from the held value. A change therefore alters SMRAM routing from the next cycle on, never in the cycle it is applied.
- R11: A register write (`cfg_we` high, `cfg_sel` 0..6 attribute, 7 SMRAM control) takes effect at the next clock edge. SMRAM control stores bits 6:3 and reads bits 2:0 as 3'b010 and bit 7 as 0. Bits 5 (close) and 4 (lock) are stored but do not change routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0..6 attribute, 7 SMRAM control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| smm_active | input | 1 | System-management mode level |
| req_valid | input | 1 | Access request present |
| req_addr | input | 20 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| route_o | output | 2 | 00 none, 01 DRAM, 10 PCI, 11 blocked |

## Verification
A register write can land in the same cycle as an access to the segment that register controls. Likewise, an SMM level change can coincide with an access to the SMRAM window. The bench provokes both, in directed sequences and in a long random stream where writes, SMM toggles and accesses are drawn independently each cycle. A bench model holds the old state through the access cycle and commits the write and the mode change only after the clock edge. Every sampled route must therefore reflect the state before that cycle's update.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int ADDR_W  = 20;
  localparam int REG_W   = 8;
  localparam int N_ATTR  = 7;
  localparam int SEL_W   = $clog2(N_ATTR + 1);
  localparam int N_SEG   = 2 * (N_ATTR - 1);
  localparam int SEG_SHIFT = 14;
  localparam int SEG_IDX_W = $clog2(N_SEG);

  localparam logic [ADDR_W-1:0] SMW_BASE  = 20'hA0000;
  localparam logic [ADDR_W-1:0] EXP_BASE  = 20'hC0000;
  localparam logic [ADDR_W-1:0] TOP_BASE  = 20'hF0000;

  localparam logic [REG_W-1:0] SMC_KEEP  = 8'h78;
  localparam logic [REG_W-1:0] SMC_FIXED = 8'h02;
  localparam int SMC_OPEN_BIT = 6;
  localparam int SMC_GEN_BIT  = 3;

  typedef enum logic [1:0] {
    RT_NONE  = 2'b00,
    RT_DRAM  = 2'b01,
    RT_PCI   = 2'b10,
    RT_BLOCK = 2'b11
  } route_e;

  function automatic route_e attr_route(input logic [1:0] attr, input logic is_wr);
    route_e r;
    case (attr)
      2'b11:   r = RT_DRAM;
      2'b01:   r = is_wr ? RT_BLOCK : RT_DRAM;
      default: r = RT_PCI;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lmr_regfile.sv
module lmr_regfile
  import lmr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        sel,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output logic [N_ATTR*REG_W-1:0] attr_flat,
  output logic [REG_W-1:0]        smc
);
  localparam logic [SEL_W-1:0] SMC_SEL = SEL_W'(N_ATTR);

  logic [REG_W-1:0] attr_q [N_ATTR];
  logic [REG_W-1:0] attr_n [N_ATTR];
  logic [REG_W-1:0] smc_q, smc_n;
  logic             ce;

  assign ce = wr_en;

  always_comb begin
    for (int i = 0; i < N_ATTR; i++) attr_n[i] = attr_q[i];
    smc_n = smc_q;
    if (sel == SMC_SEL) begin
      smc_n = wdata & SMC_KEEP;
    end else begin
      for (int i = 0; i < N_ATTR; i++)
        if (sel == SEL_W'(i)) attr_n[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ATTR; i++) attr_q[i] <= '0;
      smc_q <= '0;
    end else if (ce) begin
      for (int i = 0; i < N_ATTR; i++) attr_q[i] <= attr_n[i];
      smc_q <= smc_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SMC_SEL) rdata = smc_q | SMC_FIXED;
    else
      for (int i = 0; i < N_ATTR; i++)
        if (sel == SEL_W'(i)) rdata = attr_q[i];
  end

  for (genvar g = 0; g < N_ATTR; g++) begin : g_flat
    assign attr_flat[g*REG_W +: REG_W] = attr_q[g];
  end

  assign smc = smc_q;
endmodule

// File: rtl/lmr_smm_hold.sv
module lmr_smm_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic smm_in,
  output logic smm_q
);
  logic held_q, held_n, ce;

  assign ce     = (smm_in != held_q);
  assign held_n = smm_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held_q <= 1'b0;
    else if (ce) held_q <= held_n;
  end

  assign smm_q = held_q;
endmodule

// File: rtl/lmr_route_decode.sv
module lmr_route_decode
  import lmr_pkg::*;
(
  input  logic [N_ATTR*REG_W-1:0] attr_flat,
  input  logic [REG_W-1:0]        smc,
  input  logic                    smm_q,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  output logic [1:0]              route
);
  localparam int SLOTS = 1 << SEG_IDX_W;

  logic [1:0]           seg_attr [SLOTS];
  logic [1:0]           top_attr;
  logic [ADDR_W-1:0]    exp_off;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic                 smw_dram;
  route_e               r;

  for (genvar g = 0; g < SLOTS; g++) begin : g_seg
    if (g < N_SEG) begin : g_live
      assign seg_attr[g] = attr_flat[(g/2 + 1)*REG_W + (g%2)*4 +: 2];
    end else begin : g_pad
      assign seg_attr[g] = 2'b00;
    end
  end

  assign top_attr = attr_flat[4 +: 2];
  assign exp_off  = req_addr - EXP_BASE;
  assign seg_idx  = exp_off[SEG_SHIFT +: SEG_IDX_W];
  assign smw_dram = smc[SMC_OPEN_BIT] | (smc[SMC_GEN_BIT] & smm_q);

  always_comb begin
    r = RT_NONE;
    if (req_valid) begin
      if (req_addr >= TOP_BASE)      r = attr_route(top_attr, req_write);
      else if (req_addr >= EXP_BASE) r = attr_route(seg_attr[seg_idx], req_write);
      else if (req_addr >= SMW_BASE) r = smw_dram ? RT_DRAM : RT_PCI;
    end
  end

  assign route = r;
endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              smm_active,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic [1:0]        route_o
);
  logic [N_ATTR*REG_W-1:0] attr_flat;
  logic [REG_W-1:0]        smc;
  logic                    smm_q;

  lmr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .attr_flat(attr_flat), .smc(smc)
  );

  lmr_smm_hold u_smm (
    .clk(clk), .rst_n(rst_n), .smm_in(smm_active), .smm_q(smm_q)
  );

  lmr_route_decode u_dec (
    .attr_flat(attr_flat), .smc(smc), .smm_q(smm_q),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .route(route_o)
  );
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker
  import lmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smm_active,
  input logic              smm_q,
  input logic [REG_W-1:0]  smc,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic [1:0]        route_o
);
  logic in_smw;
  assign in_smw = req_valid && (req_addr >= SMW_BASE) && (req_addr < EXP_BASE);

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> route_o == RT_NONE); // R2

  AST_LOW_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < SMW_BASE) |-> route_o == RT_NONE); // R2

  AST_WINDOW_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= SMW_BASE) |-> route_o != RT_NONE); // R4

  AST_READ_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> route_o != RT_BLOCK); // R6

  AST_SMW_OPEN_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smw && smc[SMC_OPEN_BIT]) |-> route_o == RT_DRAM); // R9

  AST_SMW_SHUT_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smw && !smc[SMC_OPEN_BIT] && !smc[SMC_GEN_BIT]) |-> route_o == RT_PCI); // R9

  AST_SMM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> smm_q == $past(smm_active)); // R10
endmodule

bind legacy_mem_router lmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smm_active(smm_active), .smm_q(smm_q), .smc(smc),
  .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
  .route_o(route_o)
);

// File: tb/legacy_mem_router_tb.sv
module legacy_mem_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        smm_active = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  route_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_pam [0:6];
  logic [7:0] m_smc;
  logic       m_smm;

  always #5 clk = ~clk;

  legacy_mem_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_active(smm_active),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .route_o(route_o)
  );

  function automatic logic [1:0] exp_route(logic v, logic [19:0] a, logic w);
    logic [1:0] at;
    int k;
    if (!v || a < 20'hA0000) return 2'b00;
    if (a < 20'hC0000) return ((m_smm && m_smc[3]) || m_smc[6]) ? 2'b01 : 2'b10;
    if (a >= 20'hF0000) at = m_pam[0][5:4];
    else begin
      k = int'((a - 20'hC0000) >> 14);
      at = (k % 2 == 1) ? m_pam[k/2 + 1][5:4] : m_pam[k/2 + 1][1:0];
    end
    case (at)
      2'b11:   return 2'b01;
      2'b01:   return w ? 2'b11 : 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic string tag_of(logic [19:0] a);
    if (a < 20'hA0000) return "R2";
    if (a < 20'hC0000) return "R9";
    if (a >= 20'hF0000) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check before the rising edge, then commit model.
  task automatic step(logic v, logic [19:0] a, logic w, logic we, logic [2:0] sel,
                      logic [7:0] d, logic smm, string tag);
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d; smm_active = smm;
    #2;
    check(tag, {6'd0, route_o}, {6'd0, exp_route(v, a, w)});
    @(posedge clk);
    if (we) begin
      if (sel == 3'd7) m_smc = d & 8'h78;
      else m_pam[sel] = d;
    end
    if (smm != m_smm) m_smm = smm;
  endtask

  task automatic acc(logic [19:0] a, logic w, string tag);
    step(1'b1, a, w, 1'b0, 3'd0, 8'h00, m_smm, tag);
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    step(1'b0, 20'h0, 1'b0, 1'b1, sel, d, m_smm, "R2");
  endtask

  task automatic rd(logic [2:0] sel, logic [7:0] exp, string tag);
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = sel; req_valid = 1'b0;
    #2;
    check(tag, cfg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 7; i++) m_pam[i] = '0;
    m_smc = '0; m_smm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) rd(3'(i), 8'h00, "R1");
    rd(3'd7, 8'h02, "R1");
    acc(20'hA0000, 1'b0, "R1");
    acc(20'hC4000, 1'b1, "R1");
    acc(20'hFFFFF, 1'b0, "R1");

    // R2 unclaimed and idle
    acc(20'h9FFFF, 1'b0, "R2");
    acc(20'h00000, 1'b1, "R2");
    step(1'b0, 20'hF0000, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, "R2");

    // R3 top segment, low nibble of reg 0 ignored
    wr(3'd0, 8'h0F);
    acc(20'hF8000, 1'b0, "R3");
    wr(3'd0, 8'h30);
    acc(20'hF0000, 1'b1, "R3_R5");
    // R11 same-cycle write: old attribute still applies
    step(1'b1, 20'hFFFFF, 1'b1, 1'b1, 3'd0, 8'h10, 1'b0, "R11");
    acc(20'hFFFFF, 1'b1, "R6");
    acc(20'hFFFFF, 1'b0, "R6");

    // R4 segment mapping, R5/R6/R7 attributes, R8 ignored bits
    wr(3'd3, 8'h23);
    acc(20'hD0000, 1'b1, "R4_R5");
    acc(20'hD4000, 1'b0, "R4_R7");
    acc(20'hCFFFF, 1'b0, "R4");
    wr(3'd6, 8'hD0);
    acc(20'hEC000, 1'b1, "R8_R6");
    acc(20'hEFFFF, 1'b0, "R8_R6");
    acc(20'hE8000, 1'b0, "R7");
    wr(3'd1, 8'hEC);
    acc(20'hC0000, 1'b0, "R8_R7");
    acc(20'hC4000, 1'b1, "R8");

    // R9 / R10 SMRAM window
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h7A, "R11");
    acc(20'hA0000, 1'b1, "R9");
    wr(3'd7, 8'h30);
    rd(3'd7, 8'h32, "R11");
    acc(20'hBFFFF, 1'b0, "R11_R9");
    wr(3'd7, 8'h08);
    acc(20'hB0000, 1'b0, "R9");
    step(1'b1, 20'hB0000, 1'b1, 1'b0, 3'd0, 8'h00, 1'b1, "R10");
    acc(20'hB0000, 1'b1, "R10");
    step(1'b1, 20'hA8000, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R10");
    step(1'b1, 20'hA8000, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, "R10");
    acc(20'hA8000, 1'b0, "R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] a;
      logic we;
      a = 20'($urandom);
      if ($urandom % 4 != 0) a[19:18] = 2'b11;
      we = ($urandom % 5 == 0);
      step($urandom % 8 != 0, a, 1'($urandom), we, 3'($urandom), 8'($urandom),
           ($urandom % 6 == 0) ? ~m_smm : m_smm, tag_of(a));
      if (n % 500 == 0) rd(3'd7, m_smc | 8'h02, "R11");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule